// File: doc/BRIEF.md
# CAN Soft-Reset and Bus-Integration Controller

This block owns the soft-reset state of a CAN protocol controller. A CPU register port sets and clears one soft-reset bit in the main control register. Entering soft reset cancels any frame activity. A one-cycle abort pulse goes to the frame engine, and bus synchronization is dropped. While soft reset is active, the operating registers are forced to zero and held there. The configuration registers (second control, two bit-timing, acceptance control, four acceptance codes and four acceptance masks) can be written only in this state. The transmit and receive error counters are loaded by the frame engine and are never touched by soft reset.

When soft reset is released, the block counts strobed recessive samples of the received bus level. A node that is not bus-off is synchronized after one unbroken run of eleven recessive samples. A bus-off node must complete 128 such runs. On the last run it emits a one-cycle pulse that clears the bus-off condition. A dominant sample restarts the current run but keeps the count of finished runs.

Top module: `can_srst_ctrl`

## Requirements
- R1: After `rst_n` is released, the main register (address 0x00) reads 0x01, with bit 0 as the soft-reset bit. Every other register reads 0x00 and `bus_synced` is low.
- R2: Writing the main register with bit 0 = 1 while operating does three things: soft reset becomes active, `abort_pulse` is high for one cycle, and `bus_synced` goes low. Main bits 7:1 and the registers at 0x01–0x04 then read 0x00, and CPU writes to them are ignored while soft reset lasts.
- R3: The configuration registers at 0x05–0x10 accept writes only while soft reset is active. At any other time a write leaves them unchanged.
- R4: `err_ld` loads the error counters, which read at 0x11 (transmit) and 0x12 (receive). Entering or leaving soft reset does not change them.
- R5: After soft reset clears with `bus_off` low, `bus_synced` rises in the cycle after the strobe (`smp_stb`) that samples the 11th consecutive recessive (`rx_bit` = 1) level. Samples are ignored while soft reset is active.
- R6: A dominant strobed sample restarts the recessive run from zero but does not reset the count of completed runs.
- R7: With `bus_off` high, synchronization needs 128 completed runs. `busoff_clr` pulses for exactly one cycle, in the same cycle that `bus_synced` rises.
- R8: A write that clears the soft-reset bit changes only that bit. The main register then reads 0x00, whatever the other written bits were.
- R9: Writing bit 0 = 1 to the main register while soft reset is active changes nothing. The register still reads 0x01.
- R10: If a write that sets soft reset and a strobe that completes a recessive run occur in the same cycle, soft reset wins and `bus_synced` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 5 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| err_ld | input | 1 | Error counter load from frame engine |
| err_tx_in | input | 8 | New transmit error count |
| err_rx_in | input | 8 | New receive error count |
| smp_stb | input | 1 | Bit sample-point strobe |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| bus_off | input | 1 | Node is bus-off |
| bus_synced | output | 1 | Synchronized to the bus |
| busoff_clr | output | 1 | One-cycle pulse ending bus-off |
| abort_pulse | output | 1 | One-cycle abort of frame activity |

## Verification
Two functions can fall in the same cycle: a CPU write that enters soft reset, and a sample strobe that would complete the eleventh recessive bit and synchronize the node. The bench releases soft reset and feeds ten recessive samples. It then drives the setting write and the eleventh recessive strobe on the same clock edge. It judges the result by `bus_synced` staying low, `abort_pulse` firing, and the main register reading back 0x01.

// File: rtl/can_srst_pkg.sv
// Package: shared widths and the register address map of the soft-reset
// controller. Assumes an 8-bit CPU data path and a 5-bit register address.
package can_srst_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int A_MAIN   = 0;   // soft-reset bit at position 0
    localparam int A_HELD0  = 1;   // first held register
    localparam int N_HELD   = 4;   // rx flags, rx irq enable, tx flags, tx control
    localparam int A_LOCK0  = 5;   // first locked configuration register
    localparam int N_LOCK   = 12;  // ctrl2, timing x2, accept ctrl, codes x4, masks x4
    localparam int A_TEC    = 17;
    localparam int A_REC    = 18;
endpackage

// File: rtl/can_srst_regs.sv
// Module: CPU register file of the controller. Owns the soft-reset bit,
// the registers held at reset during soft reset, the write-locked
// configuration registers and the error counters. Assumes one write per
// cycle and a combinational read path.
module can_srst_regs
    import can_srst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              err_ld,
    input  logic [DATA_W-1:0] err_tx_in,
    input  logic [DATA_W-1:0] err_rx_in,
    output logic              srst,
    output logic              srst_next,
    output logic              abort,
    output logic [DATA_W-1:0] timing0,
    output logic [DATA_W-1:0] tec,
    output logic [DATA_W-1:0] rec
);
    logic              srst_q;
    logic              abort_q;
    logic [DATA_W-1:1] main_hi_q;
    logic [DATA_W-1:0] held_q [N_HELD];
    logic [DATA_W-1:0] lock_q [N_LOCK];
    logic [DATA_W-1:0] tec_q, rec_q;
    logic              main_wr;

    assign main_wr = we && (addr == ADDR_W'(A_MAIN));

    // Next soft-reset state: set from operation, clear from soft reset.
    always_comb begin
        srst_next = srst_q;
        if (main_wr) begin
            if (!srst_q && wdata[0])
                srst_next = 1'b1;
            else if (srst_q && !wdata[0])
                srst_next = 1'b0;
        end
    end

    // Soft-reset bit and abort pulse on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q  <= 1'b1;
            abort_q <= 1'b0;
        end else begin
            srst_q  <= srst_next;
            abort_q <= !srst_q && srst_next;
        end
    end

    // Upper main-control bits: written only while operating.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_next)
            main_hi_q <= '0;
        else if (main_wr && !srst_q)
            main_hi_q <= wdata[DATA_W-1:1];
    end

    // Held registers: forced to zero while soft reset is active.
    for (genvar i = 0; i < N_HELD; i++) begin : g_held
        always_ff @(posedge clk) begin
            if (!rst_n || srst_next)
                held_q[i] <= '0;
            else if (we && addr == ADDR_W'(A_HELD0 + i))
                held_q[i] <= wdata;
        end
    end

    // Configuration registers: writable only in soft reset.
    for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[i] <= '0;
            else if (we && srst_q && addr == ADDR_W'(A_LOCK0 + i))
                lock_q[i] <= wdata;
        end
    end

    // Error counters: loaded by the frame engine, untouched by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tec_q <= '0;
            rec_q <= '0;
        end else if (err_ld) begin
            tec_q <= err_tx_in;
            rec_q <= err_rx_in;
        end
    end

    // Read multiplexer over the address map.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_MAIN))
            rdata = {main_hi_q, srst_q};
        else if (addr == ADDR_W'(A_TEC))
            rdata = tec_q;
        else if (addr == ADDR_W'(A_REC))
            rdata = rec_q;
        for (int i = 0; i < N_HELD; i++)
            if (addr == ADDR_W'(A_HELD0 + i)) rdata = held_q[i];
        for (int i = 0; i < N_LOCK; i++)
            if (addr == ADDR_W'(A_LOCK0 + i)) rdata = lock_q[i];
    end

    assign srst    = srst_q;
    assign abort   = abort_q;
    assign timing0 = lock_q[1];
    assign tec     = tec_q;
    assign rec     = rec_q;
endmodule

// File: rtl/can_srst_integ.sv
// Module: bus-integration counter. Counts strobed recessive samples after
// soft reset is released. One run of RUN_LEN recessive samples
// synchronizes a normal node; a bus-off node needs SEQ_NUM runs and then
// pulses a bus-off clear. Assumes srst_in is the next-state soft-reset value.
module can_srst_integ #(
    parameter int RUN_LEN = 11,
    parameter int SEQ_NUM = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_in,
    input  logic smp_stb,
    input  logic rx_bit,
    input  logic bus_off,
    output logic synced,
    output logic boff_clr
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(SEQ_NUM + 1);

    logic [RUN_W-1:0] run_q;
    logic [SEQ_W-1:0] seq_q;
    logic             synced_q, clr_q;

    // Run and sequence counting until synchronized.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_in) begin
            run_q    <= '0;
            seq_q    <= '0;
            synced_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (!synced_q && smp_stb) begin
                if (!rx_bit) begin
                    run_q <= '0;
                end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
                    run_q <= '0;
                    if (!bus_off) begin
                        synced_q <= 1'b1;
                    end else if (seq_q == SEQ_W'(SEQ_NUM - 1)) begin
                        synced_q <= 1'b1;
                        clr_q    <= 1'b1;
                        seq_q    <= '0;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign synced   = synced_q;
    assign boff_clr = clr_q;
endmodule

// File: rtl/can_srst_ctrl.sv
// Module: top of the soft-reset and bus-integration controller. Joins the
// register file and the integration counter. Assumes rx_bit is already
// sampled at the bit sample point marked by smp_stb.
module can_srst_ctrl
    import can_srst_pkg::*;
#(
    parameter int RUN_LEN = 11,
    parameter int SEQ_NUM = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              err_ld,
    input  logic [DATA_W-1:0] err_tx_in,
    input  logic [DATA_W-1:0] err_rx_in,
    input  logic              smp_stb,
    input  logic              rx_bit,
    input  logic              bus_off,
    output logic              bus_synced,
    output logic              busoff_clr,
    output logic              abort_pulse
);
    logic              srst_w, srst_next_w;
    logic [DATA_W-1:0] timing0_w, tec_w, rec_w;

    can_srst_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cpu_we),
        .addr      (cpu_addr),
        .wdata     (cpu_wdata),
        .rdata     (cpu_rdata),
        .err_ld    (err_ld),
        .err_tx_in (err_tx_in),
        .err_rx_in (err_rx_in),
        .srst      (srst_w),
        .srst_next (srst_next_w),
        .abort     (abort_pulse),
        .timing0   (timing0_w),
        .tec       (tec_w),
        .rec       (rec_w)
    );

    can_srst_integ #(.RUN_LEN(RUN_LEN), .SEQ_NUM(SEQ_NUM)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_in  (srst_next_w),
        .smp_stb  (smp_stb),
        .rx_bit   (rx_bit),
        .bus_off  (bus_off),
        .synced   (bus_synced),
        .boff_clr (busoff_clr)
    );
endmodule

// File: rtl/can_srst_chk.sv
// Module: property checker bound to the controller top.
module can_srst_chk
    import can_srst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              smp_stb,
    input logic              rx_bit,
    input logic              err_ld,
    input logic              bus_synced,
    input logic              busoff_clr,
    input logic              abort_pulse,
    input logic              srst,
    input logic [DATA_W-1:0] timing0,
    input logic [DATA_W-1:0] tec,
    input logic [DATA_W-1:0] rec
);
    assert_abort_drops_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (srst && !bus_synced));

    assert_no_sync_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |-> !bus_synced);

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !srst && cpu_addr == ADDR_W'(A_LOCK0 + 1)) |=> $stable(timing0));

    assert_err_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !err_ld |=> ($stable(tec) && $stable(rec)));

    assert_sync_on_recessive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_synced) |-> $past(smp_stb && rx_bit));

    assert_clr_with_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_clr |-> $rose(bus_synced));
endmodule

bind can_srst_ctrl can_srst_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .smp_stb     (smp_stb),
    .rx_bit      (rx_bit),
    .err_ld      (err_ld),
    .bus_synced  (bus_synced),
    .busoff_clr  (busoff_clr),
    .abort_pulse (abort_pulse),
    .srst        (srst_w),
    .timing0     (timing0_w),
    .tec         (tec_w),
    .rec         (rec_w)
);

// File: tb/sim_can_srst_ctrl.sv
`timescale 1ns/1ps
module sim_can_srst_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       err_ld = 1'b0;
    logic [7:0] err_tx_in = '0, err_rx_in = '0;
    logic       smp_stb = 1'b0, rx_bit = 1'b1, bus_off = 1'b0;
    logic       bus_synced, busoff_clr, abort_pulse;

    typedef struct {
        string req;
        int    sel;   // 0 rdata, 1 bus_synced, 2 busoff_clr, 3 abort_pulse
        int    exp;
    } item_t;
    item_t sb_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    can_srst_ctrl u0 (.*);

    // Monitor: pops expected items and compares at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int got;
            it = sb_q.pop_front();
            case (it.sel)
                0: got = int'(cpu_rdata);
                1: got = int'(bus_synced);
                2: got = int'(busoff_clr);
                default: got = int'(abort_pulse);
            endcase
            checks++;
            if (got != it.exp) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", it.req, got, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic expect_sig(string req, int sel, int exp);
        sb_q.push_back('{req, sel, exp});
    endtask
    task automatic expect_rd(string req, int a, int exp);
        cpu_addr = 5'(a);
        sb_q.push_back('{req, 0, exp});
        tick();
    endtask
    task automatic wr(int a, int d);
        cpu_we = 1'b1; cpu_addr = 5'(a); cpu_wdata = 8'(d);
        tick();
        cpu_we = 1'b0;
    endtask
    task automatic sample(bit b);
        rx_bit = b; smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
    endtask
    task automatic run_ones(int n);
        for (int k = 0; k < n; k++) sample(1'b1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        expect_sig("R1 sync low", 1, 0);
        expect_rd("R1 main", 0, 8'h01);
        expect_rd("R1 held", 2, 8'h00);
        // R9: setting again in soft reset does nothing; R2 held ignored
        wr(0, 8'hFF);
        expect_rd("R9 main", 0, 8'h01);
        wr(2, 8'h0F);
        expect_rd("R2 held write in srst", 2, 8'h00);
        // R3 config writable in soft reset
        wr(6, 8'h5A);
        expect_rd("R3 cfg in srst", 6, 8'h5A);
        // strobes in soft reset ignored (R5)
        run_ones(12);
        expect_sig("R5 no sync in srst", 1, 0);
        // R8 clear only the bit
        wr(0, 8'hF0);
        expect_rd("R8 main after clear", 0, 8'h00);
        wr(6, 8'h33);
        expect_rd("R3 cfg locked", 6, 8'h5A);
        wr(0, 8'hE0);
        expect_rd("R2 main bits operate", 0, 8'hE0);
        wr(2, 8'h0F);
        expect_rd("R2 held write operate", 2, 8'h0F);
        // R6/R5 run with a break
        run_ones(10);
        sample(1'b0);
        expect_sig("R6 dominant restarts", 1, 0);
        run_ones(10);
        expect_sig("R5 ten not enough", 1, 0);
        sample(1'b1);
        expect_sig("R5 synced at 11th", 1, 1);
        tick();
        // R4 counters and R2 entry
        err_tx_in = 8'h07; err_rx_in = 8'h09; err_ld = 1'b1;
        tick();
        err_ld = 1'b0;
        wr(0, 8'h01);
        expect_sig("R2 abort pulse", 3, 1);
        expect_sig("R2 sync dropped", 1, 0);
        tick();
        expect_sig("R2 abort one cycle", 3, 0);
        expect_rd("R2 main held", 0, 8'h01);
        expect_rd("R2 held cleared", 2, 8'h00);
        expect_rd("R4 tec kept", 17, 8'h07);
        // R7 bus-off integration
        bus_off = 1'b1;
        wr(0, 8'h00);
        expect_rd("R4 rec kept", 18, 8'h09);
        for (int s = 0; s < 127; s++) begin
            if (s == 5) begin run_ones(5); sample(1'b0); end
            run_ones(11);
        end
        expect_sig("R7 not yet synced", 1, 0);
        expect_sig("R7 no clear yet", 2, 0);
        tick();
        run_ones(10);
        sample(1'b1);
        expect_sig("R7 synced at 128", 1, 1);
        expect_sig("R7 clear pulse", 2, 1);
        tick();
        expect_sig("R7 pulse one cycle", 2, 0);
        tick();
        bus_off = 1'b0;
        // R10 same-cycle set and completing strobe
        wr(0, 8'h01);
        wr(0, 8'h00);
        run_ones(10);
        cpu_we = 1'b1; cpu_addr = 5'd0; cpu_wdata = 8'h01;
        rx_bit = 1'b1; smp_stb = 1'b1;
        tick();
        cpu_we = 1'b0; smp_stb = 1'b0;
        expect_sig("R10 srst wins", 1, 0);
        expect_sig("R10 abort", 3, 1);
        tick();
        expect_rd("R10 main", 0, 8'h01);
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule